// File: doc/BRIEF.md
# Bidirectional Barrel Shifter with Normalization

This block is the shift unit of a 16-bit fixed-point datapath. It takes a 16-bit operand and places it in the upper or lower half of a 32-bit field. It then shifts that field left or right by a signed amount and registers the outcome. A positive amount shifts left and a negative amount shifts right. Logical and arithmetic variants are provided. In the arithmetic variant, a right shift replicates the sign of the placed field.

The same hardware gives block floating-point support. The exponent-derivation operation counts the redundant sign bits of the operand and stores that count, negated, in an exponent register. The normalize operation shifts the operand left until its sign bit and the next bit differ. The denormalize operation shifts right by the magnitude held in the exponent register. Any shifting operation can OR its new value into the previous result. This lets a 32-bit word be assembled from two 16-bit halves, or a multiprecision value be shifted piece by piece. Each operation is accepted on a rising clock edge where `in_valid` is high. Its effect is visible on `result` and `expo` straight after that edge.

Top module: `shift_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted operation, `result` reads 0 and `expo` reads 0.
- R2: An operation is accepted only on a rising edge with `in_valid` high, and it updates `result`/`expo` at that edge. With `in_valid` low, both outputs hold whatever the other inputs do.
- R3: With `place_hi`=1 the operand occupies bits 31:16 and bits 15:0 are zero. With `place_hi`=0 it occupies bits 15:0, and bits 31:16 are zero for op 0 and copies of operand bit 15 for ops 1, 2 and 3.
- R4: Op code 0 is a logical shift by `shamt`, a 6-bit two's-complement value from -32 to 31. Positive values shift left, negative values shift right, vacated bits are zero, and a right shift by 32 gives 0.
- R5: Op code 1 is an arithmetic shift. A left shift behaves as in op 0. A right shift fills with bit 31 of the placed field, so a right shift by 32 gives all copies of that bit.
- R6: Op code 4 derives the exponent. `expo` (5-bit two's complement) becomes minus the number of bits below bit 15 that equal bit 15 before the first that differs, so it lies in 0 to -15. `result` is unchanged.
- R7: Op code 2 normalizes. `result` becomes the placed field shifted left by that redundant-sign-bit count, and `expo` is set exactly as op 4 would set it.
- R8: Op code 3 denormalizes. `result` becomes the placed field shifted right arithmetically by the negated current `expo`, and `expo` is unchanged.
- R9: With `or_mode`=1, ops 0 to 3 write the bitwise OR of the new shifted value and the previous `result`. With `or_mode`=0 they overwrite it.
- R10: Op codes 5, 6 and 7 leave `result` and `expo` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept the operation on this edge |
| op | input | 3 | Operation code (0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 derive exponent) |
| din | input | 16 | Operand |
| shamt | input | 6 | Signed shift amount for ops 0 and 1 |
| place_hi | input | 1 | Place operand in the upper half (1) or lower half (0) |
| or_mode | input | 1 | OR the new value into the previous result |
| result | output | 32 | Registered 32-bit result field |
| expo | output | 5 | Registered exponent, two's complement |

## Verification
The result and exponent registers are the only state. A wrong bit in either one shows on the ports at the first sample after the edge that wrote it, one cycle after the operation is presented. A corrupted exponent can also stay hidden until the next denormalize uses it as a shift distance, so the bench derives an exponent and then denormalizes in a later step. A stale or wrongly kept result shows up through OR mode, and through operations that must leave the result untouched, such as exponent derivation, reserved codes and idle cycles.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } sh_op_e;
endpackage

// File: rtl/rst_sync.sv
// Asynchronous assertion, synchronous release of an active-low reset.
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sign_count.sv
// Counts bits below the MSB that match the MSB, stopping at the first mismatch.
module sign_count #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]         word,
  output logic [$clog2(DW)-1:0] count
);
  localparam int CNT_W = $clog2(DW);

  logic [DW-2:0] run;

  assign run[DW-2] = (word[DW-2] == word[DW-1]);

  generate
    for (genvar k = DW - 3; k >= 0; k--) begin : g_run
      assign run[k] = run[k+1] & (word[k] == word[DW-1]);
    end
  endgenerate

  always_comb begin
    count = '0;
    for (int i = 0; i < DW - 1; i++) begin
      count = count + CNT_W'(run[i]);
    end
  end
endmodule

// File: rtl/bshift_core.sv
// Logarithmic bidirectional shifter with a selectable right-side fill bit.
module bshift_core #(
  parameter int RW   = 32,
  parameter int SH_W = 6
) (
  input  logic [RW-1:0]   field,
  input  logic            fill,
  input  logic [SH_W-1:0] amt,
  output logic [RW-1:0]   shifted
);
  localparam int ST = $clog2(RW);

  logic            go_left;
  logic [SH_W-1:0] mag;
  logic            too_far;

  logic [RW-1:0] lv [ST+1];
  logic [RW-1:0] rv [ST+1];

  always_comb begin
    go_left = ~amt[SH_W-1];
    mag     = go_left ? amt : (SH_W'(0) - amt);
    too_far = |mag[SH_W-1:ST];
  end

  assign lv[0] = field;
  assign rv[0] = field;

  generate
    for (genvar s = 0; s < ST; s++) begin : g_stage
      localparam int DIST = 1 << s;
      assign lv[s+1] = mag[s] ? {lv[s][RW-1-DIST:0], {DIST{1'b0}}} : lv[s];
      assign rv[s+1] = mag[s] ? {{DIST{fill}}, rv[s][RW-1:DIST]}    : rv[s];
    end
  endgenerate

  always_comb begin
    if (too_far) shifted = go_left ? '0 : {RW{fill}};
    else         shifted = go_left ? lv[ST] : rv[ST];
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DW   = 16,
  parameter int SH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2:0]            op,
  input  logic [DW-1:0]         din,
  input  logic [SH_W-1:0]       shamt,
  input  logic                  place_hi,
  input  logic                  or_mode,
  output logic [2*DW-1:0]       result,
  output logic [$clog2(DW):0]   expo
);
  localparam int RW    = 2 * DW;
  localparam int CNT_W = $clog2(DW);
  localparam int EXP_W = CNT_W + 1;

  logic              srst_n;
  logic              is_shift;
  logic              arith;
  logic [RW-1:0]     placed;
  logic              fill;
  logic [SH_W-1:0]   amt_sel;
  logic [RW-1:0]     shifted;
  logic [CNT_W-1:0]  rsb_cnt;
  logic [EXP_W-1:0]  neg_cnt;

  logic [RW-1:0]     result_d, result_q;
  logic [EXP_W-1:0]  expo_d,   expo_q;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sign_count #(.DW(DW)) u_cnt (
    .word  (din),
    .count (rsb_cnt)
  );

  // Operand decode and placement
  always_comb begin
    is_shift = (op == OP_LSH) || (op == OP_ASH) || (op == OP_NORM) || (op == OP_DENORM);
    arith    = (op == OP_ASH) || (op == OP_NORM) || (op == OP_DENORM);
    if (place_hi)   placed = {din, {DW{1'b0}}};
    else if (arith) placed = {{DW{din[DW-1]}}, din};
    else            placed = {{DW{1'b0}}, din};
    fill    = arith & placed[RW-1];
    neg_cnt = EXP_W'(0) - EXP_W'(rsb_cnt);
    case (op)
      OP_NORM:   amt_sel = SH_W'(rsb_cnt);
      OP_DENORM: amt_sel = {{(SH_W-EXP_W){expo_q[EXP_W-1]}}, expo_q};
      default:   amt_sel = shamt;
    endcase
  end

  bshift_core #(.RW(RW), .SH_W(SH_W)) u_core (
    .field   (placed),
    .fill    (fill),
    .amt     (amt_sel),
    .shifted (shifted)
  );

  // Next state
  always_comb begin
    result_d = result_q;
    expo_d   = expo_q;
    if (is_shift) begin
      result_d = shifted | (or_mode ? result_q : '0);
    end
    if ((op == OP_NORM) || (op == OP_EXP)) begin
      expo_d = neg_cnt;
    end
  end

  // State registers, clock enable = in_valid
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      result_q <= '0;
      expo_q   <= '0;
    end else if (in_valid) begin
      result_q <= result_d;
      expo_q   <= expo_d;
    end
  end

  assign result = result_q;
  assign expo   = expo_q;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int DW   = 16,
  parameter int SH_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          op,
  input logic [DW-1:0]       din,
  input logic [SH_W-1:0]     shamt,
  input logic                place_hi,
  input logic                or_mode,
  input logic [2*DW-1:0]     result,
  input logic [$clog2(DW):0] expo
);
  localparam int EXP_W = $clog2(DW) + 1;

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_clear_r1: assert (result == '0 && expo == '0);
    end
  end

  // R6: exponent never positive and never below -(DW-1)
  p_expo_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expo == '0) || (expo[EXP_W-1] && expo != {1'b1, {(EXP_W-1){1'b0}}}));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(expo)));

  p_exp_keeps_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=> $stable(result));

  p_reserved_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 3'd4) |=> ($stable(result) && $stable(expo)));

  p_or_keeps_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && or_mode && op < 3'd4) |=> ((result & $past(result)) == $past(result)));

  p_lsh_zero_place_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0 && shamt == '0 && place_hi && !or_mode)
      |=> (result == {$past(din), {DW{1'b0}}}));

  p_norm_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2 && place_hi && !or_mode && din != '0 && din != '1)
      |=> (result[2*DW-1] != result[2*DW-2]));

  p_denorm_keeps_expo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd3) |=> $stable(expo));
endmodule

bind shift_unit shift_unit_chk #(.DW(DW), .SH_W(SH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .din      (din),
  .shamt    (shamt),
  .place_hi (place_hi),
  .or_mode  (or_mode),
  .result   (result),
  .expo     (expo)
);

// File: tb/shift_unit_test.sv
module shift_unit_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [15:0] din;
  logic [5:0]  shamt;
  logic        place_hi;
  logic        or_mode;
  logic [31:0] result;
  logic [4:0]  expo;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_res;
  logic [4:0]  m_expo;

  shift_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .din(din),
    .shamt(shamt), .place_hi(place_hi), .or_mode(or_mode),
    .result(result), .expo(expo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] place(input logic [15:0] d, input logic hi, input logic ar);
    if (hi)      return {d, 16'h0};
    else if (ar) return {{16{d[15]}}, d};
    else         return {16'h0, d};
  endfunction

  function automatic logic [31:0] ref_shift(input logic [31:0] p, input logic ar, input int amt);
    int n;
    if (amt >= 0) return (amt >= 32) ? 32'h0 : (p << amt);
    n = -amt;
    if (ar) begin
      if (n >= 32) return {32{p[31]}};
      return 32'($signed(p) >>> n);
    end
    return (n >= 32) ? 32'h0 : (p >> n);
  endfunction

  function automatic int ref_cnt(input logic [15:0] d);
    int c = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      c++;
    end
    return c;
  endfunction

  // Present one operation for one edge; outputs are sampled at the next negedge.
  task automatic issue(input logic [2:0] o, input logic [15:0] d, input int amt,
                       input logic hi, input logic orm);
    @(negedge clk);
    op = o; din = d; shamt = 6'(amt); place_hi = hi; or_mode = orm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Issue and update the bench's own expectation from the requirements.
  task automatic run_op(input string tag, input logic [2:0] o, input logic [15:0] d,
                        input int amt, input logic hi, input logic orm);
    logic ar;
    logic [31:0] nv;
    int sh;
    ar = (o == 3'd1) || (o == 3'd2) || (o == 3'd3);
    sh = amt;
    if (o == 3'd2) sh = ref_cnt(d);
    if (o == 3'd3) sh = $signed(m_expo);
    issue(o, d, amt, hi, orm);
    if (o <= 3'd3) begin
      nv    = ref_shift(place(d, hi, ar), ar, sh);
      m_res = orm ? (nv | m_res) : nv;
    end
    if (o == 3'd2 || o == 3'd4) m_expo = 5'(-ref_cnt(d));
    check({tag, " result"}, result, m_res);
    check({tag, " expo"}, {27'h0, expo}, {27'h0, m_expo});
  endtask

  task automatic t_reset;
    check("R1 result after reset", result, 32'h0);
    check("R1 expo after reset", {27'h0, expo}, 32'h0);
  endtask

  task automatic t_logical;
    run_op("R4 left 4 hi",  3'd0, 16'h8421, 4, 1'b1, 1'b0);
    check("R4 literal", result, 32'h4210_0000);
    run_op("R4 right 3 lo", 3'd0, 16'h8421, -3, 1'b0, 1'b0);
    check("R3 lo zero ext", result, 32'h0000_1084);
    run_op("R4 left 31",    3'd0, 16'h0001, 31, 1'b0, 1'b0);
    run_op("R4 right 32",   3'd0, 16'hFFFF, -32, 1'b1, 1'b0);
  endtask

  task automatic t_arith;
    run_op("R5 right 4 lo neg", 3'd1, 16'h8000, -4, 1'b0, 1'b0);
    check("R3 lo sign ext", result, 32'hFFFF_F800);
    run_op("R5 right 32 hi",   3'd1, 16'hC000, -32, 1'b1, 1'b0);
    check("R5 all sign", result, 32'hFFFF_FFFF);
    run_op("R5 left 8 hi",     3'd1, 16'h00F3, 8, 1'b1, 1'b0);
  endtask

  task automatic t_exponent;
    run_op("R6 exp 0F00", 3'd4, 16'h0F00, 0, 1'b1, 1'b0);
    check("R6 literal -3", {27'h0, expo}, 32'h1D);
    run_op("R6 exp FFFF", 3'd4, 16'hFFFF, 0, 1'b1, 1'b0);
    check("R6 literal -15", {27'h0, expo}, 32'h11);
    run_op("R6 exp 4000", 3'd4, 16'h4000, 0, 1'b1, 1'b0);
    run_op("R6 exp C000", 3'd4, 16'hC000, 0, 1'b1, 1'b0);
  endtask

  task automatic t_norm_denorm;
    run_op("R7 norm 0F00", 3'd2, 16'h0F00, 0, 1'b1, 1'b0);
    check("R7 literal", result, 32'h7800_0000);
    run_op("R8 denorm 7800", 3'd3, 16'h7800, 0, 1'b1, 1'b0);
    check("R8 literal", result, 32'h0F00_0000);
    run_op("R7 norm neg lo", 3'd2, 16'hFC12, 0, 1'b0, 1'b0);
    run_op("R8 denorm neg",  3'd3, 16'h8000, 0, 1'b1, 1'b0);
  endtask

  task automatic t_or_mode;
    run_op("R9 low half",  3'd0, 16'h1234, 0, 1'b0, 1'b0);
    run_op("R9 or high",   3'd0, 16'hABCD, 0, 1'b1, 1'b1);
    check("R9 literal", result, 32'hABCD_1234);
  endtask

  task automatic t_reserved;
    for (int c = 5; c < 8; c++) begin
      run_op("R10 reserved", 3'(c), 16'h0003, 5, 1'b0, 1'b0);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    op = 3'd0; din = 16'h5A5A; shamt = 6'd1; place_hi = 1'b1; or_mode = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 idle result", result, m_res);
    check("R2 idle expo", {27'h0, expo}, {27'h0, m_expo});
  endtask

  initial begin
    in_valid = 1'b0; op = '0; din = '0; shamt = '0; place_hi = 1'b0; or_mode = 1'b0;
    m_res = '0; m_expo = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_logical;
    t_arith;
    t_exponent;
    t_norm_denorm;
    t_or_mode;
    t_reserved;
    t_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule